// File: doc/BRIEF.md
# Bit-Slice Ripple ALU

A purely combinational arithmetic/logic unit assembled from identical one-bit slices. Every slice can complement either of its operand bits before use, then forms AND, OR and a full-adder sum of the two bits. A two-bit selector picks which of these, or a fourth "less" input, becomes the slice's result bit. The slices are chained so that each carry-out feeds the next carry-in, and the external carry input enters at bit 0.

Six operations come out of four control fields. Subtraction is addition of the complemented B operand with a carry of one. NOR is the AND path fed with both operands complemented. Set-on-less-than runs a subtraction and returns the true signed ordering in bit 0 with all upper bits cleared. The ordering is the top slice's sum corrected by the signed-overflow signal. A zero flag, a signed-overflow flag and the final carry-out come out beside the result.

The block holds no state. It has no clock or reset; a surrounding datapath registers its outputs as it needs.

Top module: `ripple_alu`

## Requirements
- R1: `op_sel` selects the per-bit result: 0 gives the AND of the (possibly complemented) operands, 1 their OR, 2 the adder sum, 3 the less input. With no inversion, code 0 yields A AND B.
- R2: ADD (`inv_a`=0, `inv_b`=0, `carry_in`=0, `op_sel`=2) gives the low WIDTH bits of A+B on `result`, and bit WIDTH of that sum on `carry_out`.
- R3: SUB (`inv_a`=0, `inv_b`=1, `carry_in`=1, `op_sel`=2) gives A−B modulo 2^WIDTH, and `carry_out`=1 exactly when A ≥ B as unsigned numbers.
- R4: NOR (`inv_a`=1, `inv_b`=1, `op_sel`=0) gives the bitwise NOR of A and B for either value of `carry_in`.
- R5: AND (`op_sel`=0) and OR (`op_sel`=1), both with no inversion, give A AND B and A OR B for either value of `carry_in`.
- R6: SLT (`inv_a`=0, `inv_b`=1, `carry_in`=1, `op_sel`=3) gives 1 when A < B as two's-complement numbers and 0 otherwise. This holds also when A−B itself overflows.
- R7: With `op_sel`=3, bits WIDTH−1 down to 1 of `result` are 0 for any combination of the other controls.
- R8: `zero` is 1 exactly when every bit of `result` is 0.
- R9: `ovf` is 1 exactly when the signed sum formed by the adder (with the operands after inversion) does not fit in WIDTH bits. For ADD and SUB this is the usual two's-complement overflow.
- R10: Operand inversion applies to A as well: `inv_a`=1, `inv_b`=0, `op_sel`=2 gives (NOT A) + B + `carry_in`, with `carry_out` bit WIDTH of that sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| inv_a | input | 1 | Complement A in every slice |
| inv_b | input | 1 | Complement B in every slice |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | Per-slice result select (0 AND, 1 OR, 2 sum, 3 less) |
| result | output | WIDTH | Result word |
| zero | output | 1 | All result bits are 0 |
| ovf | output | 1 | Signed overflow of the adder chain |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The bench drives the extreme operands 0, all ones, the most negative and most positive values, and 1 in every pairing through each operation, then adds random operands. Comparing the most negative value against the most positive value under SLT makes the raw difference overflow. A design that took the top sum bit without the overflow correction would return the inverted answer there. A design that let the carry-in reach the logic paths would corrupt AND, OR and NOR on random carries. Upper result bits leaking under selector 3, a wrong overflow tap, or an inverted subtract carry each show up as mismatches against the model.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    // Per-slice result selector encoding; the numeric codes are part of the interface.
    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    localparam int unsigned SEL_BITS = 2;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_bit,
    input  logic y_bit,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    always_comb begin
        s_out = x_bit ^ y_bit ^ c_in;
        c_out = (x_bit & y_bit) | (x_bit & c_in) | (y_bit & c_in);
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import ripple_alu_pkg::*;
(
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic                flip_a,
    input  logic                flip_b,
    input  logic                c_in,
    input  logic                less_in,
    input  logic [SEL_BITS-1:0] sel,
    output logic                res_bit,
    output logic                c_out,
    output logic                sum_bit
);
    logic a_eff;
    logic b_eff;

    // Operand conditioning ahead of both the logic and adder paths.
    always_comb begin
        a_eff = a_bit ^ flip_a;
        b_eff = b_bit ^ flip_b;
    end

    alu_full_adder u_fa (
        .x_bit (a_eff),
        .y_bit (b_eff),
        .c_in  (c_in),
        .s_out (sum_bit),
        .c_out (c_out)
    );

    always_comb begin
        unique case (slice_sel_e'(sel))
            SEL_AND:  res_bit = a_eff & b_eff;
            SEL_OR:   res_bit = a_eff | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    input  logic             msb_carry_in,
    input  logic             msb_carry_out,
    input  logic             msb_sum,
    output logic             all_zero,
    output logic             sgn_ovf,
    output logic             set_less
);
    always_comb begin
        all_zero = ~|word;
        sgn_ovf  = msb_carry_in ^ msb_carry_out;
        // Sign of the true difference: raw sign corrected when the subtraction overflowed.
        set_less = msb_sum ^ sgn_ovf;
    end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]    opnd_a,
    input  logic [WIDTH-1:0]    opnd_b,
    input  logic                inv_a,
    input  logic                inv_b,
    input  logic                carry_in,
    input  logic [SEL_BITS-1:0] op_sel,
    output logic [WIDTH-1:0]    result,
    output logic                zero,
    output logic                ovf,
    output logic                carry_out
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sums;
    logic [WIDTH-1:0] less_vec;
    logic             set_less;

    assign chain[0] = carry_in;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign less_vec[i] = set_less;
            end else begin : g_upper
                assign less_vec[i] = 1'b0;
            end

            alu_slice u_slice (
                .a_bit   (opnd_a[i]),
                .b_bit   (opnd_b[i]),
                .flip_a  (inv_a),
                .flip_b  (inv_b),
                .c_in    (chain[i]),
                .less_in (less_vec[i]),
                .sel     (op_sel),
                .res_bit (result[i]),
                .c_out   (chain[i+1]),
                .sum_bit (sums[i])
            );
        end
    endgenerate

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .word          (result),
        .msb_carry_in  (chain[MSB]),
        .msb_carry_out (chain[WIDTH]),
        .msb_sum       (sums[MSB]),
        .all_zero      (zero),
        .sgn_ovf       (ovf),
        .set_less      (set_less)
    );

    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             inv_a,
    input logic             inv_b,
    input logic             carry_in,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             ovf,
    input logic             carry_out
);
    logic [WIDTH:0]   wide_add;
    logic [WIDTH-1:0] slt_word;
    logic             plain_add;
    logic             plain_sub;
    logic             plain_slt;

    always_comb begin
        wide_add  = {1'b0, opnd_a} + {1'b0, opnd_b};
        slt_word  = '0;
        slt_word[0] = ($signed(opnd_a) < $signed(opnd_b));
        plain_add = !inv_a && !inv_b && !carry_in && (op_sel == 2'd2);
        plain_sub = !inv_a &&  inv_b &&  carry_in && (op_sel == 2'd2);
        plain_slt = !inv_a &&  inv_b &&  carry_in && (op_sel == 2'd3);
    end

    always_comb begin
        // R2
        add_sum_chk: assert (!plain_add || ({carry_out, result} == wide_add))
            else $error("add mismatch");
        // R3
        sub_diff_chk: assert (!plain_sub || (result == opnd_a - opnd_b && carry_out == (opnd_a >= opnd_b)))
            else $error("sub mismatch");
        // R4
        nor_word_chk: assert (!(inv_a && inv_b && op_sel == 2'd0) || (result == ~(opnd_a | opnd_b)))
            else $error("nor mismatch");
        // R6
        slt_order_chk: assert (!plain_slt || (result == slt_word))
            else $error("slt mismatch");
        // R7
        less_upper_chk: assert (op_sel != 2'd3 || result[WIDTH-1:1] == '0)
            else $error("upper bits set under less select");
        // R8
        zero_flag_chk: assert (zero == (result == '0))
            else $error("zero flag mismatch");
        // R9
        add_ovf_chk: assert (!plain_add ||
                             (ovf == ((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) && (result[WIDTH-1] != opnd_a[WIDTH-1]))))
            else $error("add overflow mismatch");
    end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_rules (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .zero      (zero),
    .ovf       (ovf),
    .carry_out (carry_out)
);

// File: tb/ripple_alu_bench.sv
`timescale 1ns/1ps
module ripple_alu_bench;
    localparam int W = 32;

    typedef enum int {K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT, K_INVA, K_LESSRAW} kind_e;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ia;
        logic         ib;
        logic         ci;
        logic [1:0]   sel;
        logic [W-1:0] er;
        logic [W-1:0] mask;
        logic         ez;
        logic         ev;
        logic         ec;
        bit           chk_z;
        bit           chk_vc;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] opnd_a, opnd_b, result;
    logic         inv_a, inv_b, carry_in, zero, ovf, carry_out;
    logic [1:0]   op_sel;

    ripple_alu #(.WIDTH(W)) u_ripple_alu (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .inv_a     (inv_a),
        .inv_b     (inv_b),
        .carry_in  (carry_in),
        .op_sel    (op_sel),
        .result    (result),
        .zero      (zero),
        .ovf       (ovf),
        .carry_out (carry_out)
    );

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic item_t model(kind_e k, logic [W-1:0] a, logic [W-1:0] b, logic ci, logic [2:0] rnd);
        item_t it;
        logic [W:0]   s;
        logic [W-1:0] x;
        it.a = a; it.b = b; it.ia = 0; it.ib = 0; it.ci = ci; it.sel = 2'd0;
        it.mask = '1; it.chk_z = 1; it.chk_vc = 0; it.ev = 0; it.ec = 0; it.er = '0;
        case (k)
            K_ADD: begin
                it.ci = 0; it.sel = 2'd2;
                s = {1'b0, a} + {1'b0, b};
                it.er = s[W-1:0]; it.ec = s[W];
                it.ev = (a[W-1] == b[W-1]) && (it.er[W-1] != a[W-1]);
                it.chk_vc = 1; it.tag = "R2";
            end
            K_SUB: begin
                it.ib = 1; it.ci = 1; it.sel = 2'd2;
                it.er = a - b; it.ec = (a >= b);
                it.ev = (a[W-1] != b[W-1]) && (it.er[W-1] != a[W-1]);
                it.chk_vc = 1; it.tag = "R3";
            end
            K_AND: begin it.sel = 2'd0; it.er = a & b; it.tag = "R1"; end
            K_OR:  begin it.sel = 2'd1; it.er = a | b; it.tag = "R5"; end
            K_NOR: begin it.ia = 1; it.ib = 1; it.sel = 2'd0; it.er = ~(a | b); it.tag = "R4"; end
            K_SLT: begin
                it.ib = 1; it.ci = 1; it.sel = 2'd3;
                it.er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                it.tag = "R6";
            end
            K_INVA: begin
                it.ia = 1; it.sel = 2'd2;
                x = ~a;
                s = {1'b0, x} + {1'b0, b} + {{W{1'b0}}, ci};
                it.er = s[W-1:0]; it.ec = s[W];
                it.ev = (x[W-1] == b[W-1]) && (it.er[W-1] != x[W-1]);
                it.chk_vc = 1; it.tag = "R10";
            end
            default: begin
                it.ia = rnd[0]; it.ib = rnd[1]; it.ci = rnd[2]; it.sel = 2'd3;
                it.mask = {{(W-1){1'b1}}, 1'b0}; it.chk_z = 0; it.tag = "R7";
            end
        endcase
        it.ez = (it.er == '0);
        return it;
    endfunction

    task automatic drive(kind_e k, logic [W-1:0] a, logic [W-1:0] b);
        item_t it;
        it = model(k, a, b, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
        @(posedge clk);
        {opnd_a, opnd_b, inv_a, inv_b, carry_in, op_sel} = {it.a, it.b, it.ia, it.ib, it.ci, it.sel};
        q.push_back(it);
    endtask

    // Monitor: compare away from the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if ((result & it.mask) != (it.er & it.mask)) begin
                    bad++;
                    $display("FAIL %s: result got %h exp %h (mask %h)", it.tag, result, it.er, it.mask);
                end
                if (it.chk_z) begin
                    total++;
                    if (zero != it.ez) begin
                        bad++;
                        $display("FAIL R8: zero got %b exp %b (result %h)", zero, it.ez, result);
                    end
                end
                if (it.chk_vc) begin
                    total += 2;
                    if (ovf != it.ev) begin
                        bad++;
                        $display("FAIL R9: ovf got %b exp %b (%s a=%h b=%h)", ovf, it.ev, it.tag, it.a, it.b);
                    end
                    if (carry_out != it.ec) begin
                        bad++;
                        $display("FAIL %s: carry_out got %b exp %b", it.tag, carry_out, it.ec);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        finish_run();
    end

    logic [W-1:0] corners [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1};

    initial begin
        {opnd_a, opnd_b, inv_a, inv_b, carry_in, op_sel} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // zero operands through ADD: result 0, zero flag set (R2, R8)
        drive(K_ADD, 32'h0, 32'h0);
        // R6: difference overflows; true ordering must still be reported
        drive(K_SLT, 32'h8000_0000, 32'h7FFF_FFFF);
        drive(K_SLT, 32'h7FFF_FFFF, 32'h8000_0000);
        drive(K_SLT, 32'hFFFF_FFFF, 32'h0);
        // R9: positive overflow on ADD, negative on SUB
        drive(K_ADD, 32'h7FFF_FFFF, 32'h1);
        drive(K_SUB, 32'h8000_0000, 32'h1);
        for (int k = 0; k <= int'(K_LESSRAW); k++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    drive(kind_e'(k), corners[i], corners[j]);
                end
            end
        end
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k <= int'(K_LESSRAW); k++) begin
                drive(kind_e'(k), $urandom, $urandom);
            end
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule